// File: doc/BRIEF.md
# Sound Generator Noise Channel

This block is the noise voice of a programmable sound generator. A shift register produces a pseudo-random bit stream (white mode) or a short repeating pulse (periodic mode). The register advances at a rate picked by a control write. The rate is either a divided form of a prescaled clock tick or the rising edges of the third tone channel's square output. The block drives a single noise bit and holds the channel's 4-bit attenuation for the mixer downstream.

A parameter picks the register length. A 15-bit register takes its feedback from bits 0 and 1. A 16-bit register takes its feedback from bits 0 and 3. In both cases the feedback enters at the top as the contents move toward bit 0. Every control write restarts the sequence from a fixed seed. An attenuation write leaves the sequence alone. A high level on `noise_out` is the channel's quiet (low analog) level, so a freshly seeded channel always starts quiet.

Top module: `noise_chan`

## Requirements
- R1: After reset, `noise_out` is 1, `atten_q` is 4'hF, and the control holds rate field 0 in periodic mode.
- R2: In white mode (control bit 2 = 1) the 15-bit register shifts toward bit 0 once per step, and bit0 XOR bit1 enters at bit 14.
- R3: With LFSR_W = 16, white-mode feedback is bit0 XOR bit3 and enters at bit 15.
- R4: In periodic mode (control bit 2 = 0) the register rotates with no XOR. After a reseed, `noise_out` is 0 first on step LFSR_W-1 and then once every LFSR_W steps.
- R5: A control write reloads the register with only its top bit set, so `noise_out` is 1 in the next cycle. The reload wins over a step in the same cycle, and repeated writes keep the output at 1.
- R6: An attenuation write stores `atten_data` in `atten_q`. It changes neither the shift register nor the rate divider.
- R7: For control bits [1:0] = s in 0..2, counting clk_en ticks after a control write, the first step falls on tick 16<<s and later steps come every 32<<s ticks.
- R8: For control bits [1:0] = 3, the register steps on each rising edge of `tone3_out`; for other rates `tone3_out` is ignored.
- R9: With the rates 0..2 selected, no step happens in a cycle without `clk_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Prescaled clock tick |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_data | input | 3 | [2] white mode, [1:0] rate select |
| atten_we | input | 1 | Attenuation write strobe |
| atten_data | input | 4 | Attenuation value |
| tone3_out | input | 1 | Square output of tone channel 3 |
| noise_out | output | 1 | Inverse of register bit 0 |
| atten_q | output | 4 | Stored attenuation |

## Verification
The bench runs 15-bit and 16-bit instances side by side against a reference register model. A wrong tap would make the two white streams diverge from the model within a few steps. A seed other than the top bit, or a non-inverted output, shows up as a wrong first value after a write. The bench counts ticks to the first low pulse of a periodic sequence at each divider rate; an off-by-one divider or a missing half-rate toggle moves that pulse by 16 or more ticks. It also writes the control register in the same cycle as a tone edge, and writes the attenuation in the middle of a sequence. The first case catches a design where the step wins over the reload. The second catches a design where the attenuation write restarts the sequence or the divider.

// File: rtl/noise_pkg.sv
package noise_pkg;
  typedef enum logic [1:0] {
    RATE_DIV16 = 2'd0,
    RATE_DIV32 = 2'd1,
    RATE_DIV64 = 2'd2,
    RATE_TONE3 = 2'd3
  } rate_e;

  typedef struct packed {
    logic  white;
    rate_e rate;
  } nctl_t;

  localparam nctl_t CTL_RST = '{white: 1'b0, rate: RATE_DIV16};
endpackage

// File: rtl/noise_rate_div.sv
module noise_rate_div
  import noise_pkg::*;
#(
  parameter int unsigned BASE_DIV = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  clr,
  input  rate_e rate,
  input  logic  tone3,
  output logic  shift
);
  localparam int unsigned MAX_DIV = BASE_DIV * 4;
  localparam int unsigned CNT_W   = $clog2(MAX_DIV);

  logic [CNT_W-1:0] cnt_q, cnt_d, lim_m1;
  logic             ph_q, ph_d, t3_q, wrap;

  always_comb begin
    case (rate)
      RATE_DIV16: lim_m1 = CNT_W'(BASE_DIV - 1);
      RATE_DIV32: lim_m1 = CNT_W'(2 * BASE_DIV - 1);
      default:    lim_m1 = CNT_W'(4 * BASE_DIV - 1);
    endcase
  end

  assign wrap = (cnt_q == lim_m1);

  always_comb begin
    cnt_d = cnt_q;
    ph_d  = ph_q;
    if (clr) begin
      cnt_d = '0;
      ph_d  = 1'b0;
    end else if (tick) begin
      if (wrap) begin
        cnt_d = '0;
        ph_d  = ~ph_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  // step on the rising half of the internal noise clock
  assign shift = (rate == RATE_TONE3) ? (tone3 && !t3_q)
                                      : (tick && wrap && !ph_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
      t3_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
      t3_q  <= tone3;
    end
  end

  assert_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && rate != RATE_TONE3) |-> tick);

  assert_div_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !tick) |=> ($stable(cnt_q) && $stable(ph_q)));
endmodule

// File: rtl/noise_shreg.sv
module noise_shreg #(
  parameter int unsigned LFSR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              white,
  output logic [LFSR_W-1:0] q
);
  localparam logic [LFSR_W-1:0] SEED = LFSR_W'(1) << (LFSR_W - 1);

  logic [LFSR_W-1:0] q_q, q_d;
  logic              tap, fb;

  // the register length picks the second feedback tap
  generate
    if (LFSR_W == 16) begin : g_tap16
      assign tap = q_q[3];
    end else begin : g_tap15
      assign tap = q_q[1];
    end
  endgenerate

  assign fb = white ? (q_q[0] ^ tap) : q_q[0];

  always_comb begin
    q_d = q_q;
    if (load)      q_d = SEED;
    else if (step) q_d = {fb, q_q[LFSR_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= SEED;
    else        q_q <= q_d;
  end

  assign q = q_q;

  assert_seed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q_q == SEED));

  assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(q_q));

  assert_rotate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !white) |=> ($countones(q_q) == 1));

  assert_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    q_q != '0);
endmodule

// File: rtl/noise_chan.sv
module noise_chan
  import noise_pkg::*;
#(
  parameter int unsigned LFSR_W   = 15,
  parameter int unsigned BASE_DIV = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_en,
  input  logic       ctrl_we,
  input  logic [2:0] ctrl_data,
  input  logic       atten_we,
  input  logic [3:0] atten_data,
  input  logic       tone3_out,
  output logic       noise_out,
  output logic [3:0] atten_q
);
  logic              rst_meta, rst_sync;
  nctl_t             ctl_q, ctl_d;
  logic [3:0]        att_q, att_d;
  logic              shift;
  logic [LFSR_W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  always_comb begin
    ctl_d = ctrl_we  ? nctl_t'(ctrl_data) : ctl_q;
    att_d = atten_we ? atten_data         : att_q;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      ctl_q <= CTL_RST;
      att_q <= 4'hF;
    end else begin
      ctl_q <= ctl_d;
      att_q <= att_d;
    end
  end

  noise_rate_div #(.BASE_DIV(BASE_DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_sync),
    .tick  (clk_en),
    .clr   (ctrl_we),
    .rate  (ctl_q.rate),
    .tone3 (tone3_out),
    .shift (shift)
  );

  noise_shreg #(.LFSR_W(LFSR_W)) u_sr (
    .clk   (clk),
    .rst_n (rst_sync),
    .load  (ctrl_we),
    .step  (shift),
    .white (ctl_q.white),
    .q     (sr)
  );

  assign noise_out = ~sr[0];
  assign atten_q   = att_q;

  assert_quiet_after_write_R5: assert property (@(posedge clk) disable iff (!rst_sync)
    ctrl_we |=> noise_out);

  assert_atten_store_R6: assert property (@(posedge clk) disable iff (!rst_sync)
    atten_we |=> (atten_q == $past(atten_data)));
endmodule

// File: tb/noise_chan_test.sv
module noise_chan_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst_n, clk_en, ctrl_we, atten_we, tone3_out;
  logic [2:0] ctrl_data;
  logic [3:0] atten_data;
  logic       out15, out16;
  logic [3:0] att15, att16;

  int total = 0;
  int bad   = 0;
  logic [15:0] m15, m16;
  logic        mwhite;

  always #4 clk = ~clk;

  noise_chan #(.LFSR_W(15)) uut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .ctrl_we(ctrl_we),
    .ctrl_data(ctrl_data), .atten_we(atten_we), .atten_data(atten_data),
    .tone3_out(tone3_out), .noise_out(out15), .atten_q(att15));

  noise_chan #(.LFSR_W(16)) uut_w16 (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .ctrl_we(ctrl_we),
    .ctrl_data(ctrl_data), .atten_we(atten_we), .atten_data(atten_data),
    .tone3_out(tone3_out), .noise_out(out16), .atten_q(att16));

  // {ctrl[2:0], step count}; expected bits come from the reference model
  localparam logic [9:0] VEC [6] = '{
    {3'b111, 7'd40}, {3'b011, 7'd34}, {3'b111, 7'd20},
    {3'b011, 7'd16}, {3'b111, 7'd50}, {3'b011, 7'd33}
  };

  function automatic logic [15:0] mstep(logic [15:0] r, int w, logic wh);
    logic fb;
    fb = wh ? (r[0] ^ ((w == 16) ? r[3] : r[1])) : r[0];
    if (w == 16) return {fb, r[15:1]};
    return {1'b0, fb, r[14:1]};
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_ctrl(logic [2:0] v);
    ctrl_we = 1'b1; ctrl_data = v;
    cyc();
    ctrl_we = 1'b0;
    m15 = 16'h4000; m16 = 16'h8000; mwhite = v[2];
  endtask

  task automatic pulse();
    tone3_out = 1'b1;
    cyc();
    m15 = mstep(m15, 15, mwhite);
    m16 = mstep(m16, 16, mwhite);
    tone3_out = 1'b0;
    cyc();
  endtask

  task automatic chk_model(string tag);
    chk(tag, {15'd0, out15}, {15'd0, ~m15[0]});
    chk(tag, {15'd0, out16}, {15'd0, ~m16[0]});
  endtask

  initial begin
    #1200000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clk_en = 1'b0; ctrl_we = 1'b0; atten_we = 1'b0;
    tone3_out = 1'b0; ctrl_data = 3'd0; atten_data = 4'd0;
    m15 = 16'h4000; m16 = 16'h8000; mwhite = 1'b0;
    repeat (3) cyc();
    // R1 reset state
    chk("R1 out15", {15'd0, out15}, 16'd1);
    chk("R1 out16", {15'd0, out16}, 16'd1);
    chk("R1 atten", {12'd0, att15}, 16'hF);
    rst_n = 1'b1;
    repeat (4) cyc();
    chk("R1 out after release", {15'd0, out15}, 16'd1);

    // table walk: R2/R3 white, R4 periodic, R5 reseed, R8 tone3 steps
    foreach (VEC[i]) begin
      wr_ctrl(VEC[i][9:7]);
      chk("R5 reseed 15", {15'd0, out15}, 16'd1);
      chk("R5 reseed 16", {15'd0, out16}, 16'd1);
      for (int n = 0; n < int'(VEC[i][6:0]); n++) begin
        pulse();
        chk_model(mwhite ? "R2/R3 white R8" : "R4 periodic R8");
      end
    end

    // R4 explicit pulse positions
    wr_ctrl(3'b011);
    for (int n = 1; n <= 16; n++) begin
      pulse();
      if (n == 13) chk("R4 15 before", {15'd0, out15}, 16'd1);
      if (n == 14) chk("R4 15 low", {15'd0, out15}, 16'd0);
      if (n == 15) chk("R4 16 low", {15'd0, out16}, 16'd0);
    end

    // R6 attenuation write mid-sequence
    wr_ctrl(3'b111);
    repeat (10) pulse();
    atten_we = 1'b1; atten_data = 4'h5;
    cyc();
    atten_we = 1'b0;
    chk("R6 atten stored", {12'd0, att15}, 16'h5);
    chk("R6 atten stored 16", {12'd0, att16}, 16'h5);
    chk_model("R6 register kept");
    for (int n = 0; n < 12; n++) begin
      pulse();
      chk_model("R6 sequence continues");
    end

    // R5 write together with tone edges
    for (int n = 0; n < 12; n++) begin
      ctrl_we = 1'b1; ctrl_data = 3'b111; tone3_out = 1'b1;
      cyc();
      tone3_out = 1'b0;
      cyc();
      chk("R5 spam held", {15'd0, out15}, 16'd1);
    end
    ctrl_we = 1'b0;
    m15 = 16'h4000; m16 = 16'h8000; mwhite = 1'b1;
    for (int n = 0; n < 6; n++) begin
      pulse();
      chk_model("R5 after spam");
    end

    // R7 divider rates, R8/R9 ignore tone3 and idle ticks
    for (int s = 0; s < 3; s++) begin
      int d;
      d = 16 << s;
      wr_ctrl({1'b0, 2'(s)});
      if (s == 0) begin
        repeat (10) begin
          tone3_out = 1'b1; cyc(); tone3_out = 1'b0; cyc();
        end
        repeat (200) cyc();
        chk("R8 R9 no step", {15'd0, out15}, 16'd1);
      end
      clk_en = 1'b1;
      for (int t = 1; t <= 29 * d; t++) begin
        if (t == 100) begin atten_we = 1'b1; atten_data = 4'h9; end
        cyc();
        atten_we = 1'b0;
        if (t == 27 * d - 1) chk("R7 15 before", {15'd0, out15}, 16'd1);
        if (t == 27 * d)     chk("R7 15 pulse", {15'd0, out15}, 16'd0);
        if (t == 29 * d - 1) chk("R7 16 before", {15'd0, out16}, 16'd1);
        if (t == 29 * d)     chk("R7 16 pulse", {15'd0, out16}, 16'd0);
      end
      clk_en = 1'b0;
    end
    chk("R6 atten during rate", {12'd0, att15}, 16'h9);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule